// File: doc/BRIEF.md
# Masked Register Readback Sequencer

This block is the read side of a single-channel DMA controller's command port. Software first writes a read-select command, and the byte after it is a 7-bit select mask. Each later IO read of the port then returns one internal value. The sequencer steps through the enabled values in a fixed order. After the last enabled value it starts again at the first one, and this wrap has no end.

The values returned are the transfer engine's live working registers: the byte counter and the two port pointers as they are in the current cycle. The values written at setup time are not returned. The status item is a placeholder that always reads as a fixed parameter value. The read data is driven combinationally from the current read position and the live inputs, so it is valid in the same cycle that the read strobe is sampled. The read strobe then moves the position at the clock edge.

Top module: `readback_seq`

## Requirements
- R1: After reset the select mask has all seven bits set and the read position is item 0, so the first read returns the status byte.
- R2: When `mask_load` is high at a clock edge, the mask takes the value of `mask_in`, and the read position moves to the lowest-numbered enabled item.
- R3: Mask bit k enables item k. The items are: 0 status byte, 1 counter bits 7:0, 2 counter bits 15:8, 3 port A pointer bits 7:0, 4 port A pointer bits 15:8, 5 port B pointer bits 7:0, 6 port B pointer bits 15:8.
- R4: When `rd_strobe` is high at a clock edge and the mask is non-zero, the position moves to the next higher-numbered enabled item. Disabled items are skipped.
- R5: After the highest enabled item has been read, the next read returns the lowest enabled item. With one item enabled, every read returns that item.
- R6: `rd_data` follows the current `byte_cnt`, `addr_a` and `addr_b` in the same cycle. A change on them shows up at once, with no strobe needed.
- R7: While the mask is zero, `rd_data` is 0xFF, and a strobe does not move the read position.
- R8: The status item always reads as the constant parameter `STATUS_BYTE`, which defaults to 0x5A.
- R9: If `mask_load` and `rd_strobe` are both high at the same edge, the load takes effect and the strobe is ignored. The position is set to the lowest enabled item of the new mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_load | input | 1 | One-cycle pulse: the byte after the read-select command has arrived |
| mask_in | input | 7 | New select mask |
| rd_strobe | input | 1 | One-cycle pulse: an IO read of the port completes |
| byte_cnt | input | 16 | Live transfer byte counter |
| addr_a | input | 16 | Live port A next-transfer pointer |
| addr_b | input | 16 | Live port B next-transfer pointer |
| rd_data | output | 8 | Value for the current read |

## Verification
The assertions assume that `mask_load` and `rd_strobe` are single-cycle pulses that arrive after reset is released. They also assume that each read is a single strobe and is not held high over many cycles.

The bench drives every pulse for exactly one cycle, on the falling edge. Random masks include zero and single-bit values. The live inputs are changed randomly between reads. A directed case drives the load and the strobe in the same cycle, which exercises the priority rule that the assertions also rely on.

// File: rtl/rb_pkg.sv
package rb_pkg;
    localparam int ITEMS = 7;
    localparam int IDX_W = $clog2(ITEMS);
    localparam int WORDS = (ITEMS - 1) / 2;

    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [ITEMS-1:0] sel_t;

    typedef struct packed {
        sel_t mask;
        idx_t ptr;
    } rb_state_t;
endpackage

// File: rtl/rb_pick.sv
module rb_pick
    import rb_pkg::*;
(
    input  sel_t mask,
    input  idx_t start,
    output logic found,
    output idx_t idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < ITEMS; i++) begin
            int cand;
            cand = (int'(start) + i) % ITEMS;
            if (!found && mask[cand]) begin
                found = 1'b1;
                idx   = idx_t'(cand);
            end
        end
    end
endmodule

// File: rtl/rb_mux.sv
module rb_mux
    import rb_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] STATUS_BYTE = 8'h5A,
    localparam int WORD_W = 2 * DATA_W
) (
    input  idx_t              sel,
    input  logic [WORD_W-1:0] cnt,
    input  logic [WORD_W-1:0] ptr_a,
    input  logic [WORD_W-1:0] ptr_b,
    output logic [DATA_W-1:0] data
);
    logic [WORD_W-1:0] words [WORDS];
    logic [DATA_W-1:0] items [ITEMS];

    assign words[0] = cnt;
    assign words[1] = ptr_a;
    assign words[2] = ptr_b;
    assign items[0] = STATUS_BYTE;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        assign items[1 + 2*w] = words[w][DATA_W-1:0];
        assign items[2 + 2*w] = words[w][WORD_W-1:DATA_W];
    end

    always_comb begin
        data = items[0];
        for (int i = 0; i < ITEMS; i++) begin
            if (int'(sel) == i) data = items[i];
        end
    end
endmodule

// File: rtl/readback_seq.sv
module readback_seq
    import rb_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] STATUS_BYTE = 8'h5A,
    localparam int WORD_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_load,
    input  logic [ITEMS-1:0]  mask_in,
    input  logic              rd_strobe,
    input  logic [WORD_W-1:0] byte_cnt,
    input  logic [WORD_W-1:0] addr_a,
    input  logic [WORD_W-1:0] addr_b,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [DATA_W-1:0] EMPTY_DATA = '1;

    rb_state_t st_d, st_q;
    idx_t      succ_start;
    idx_t      load_idx, succ_idx;
    logic      load_found, succ_found;
    logic [DATA_W-1:0] item_data;

    assign succ_start = (int'(st_q.ptr) == ITEMS - 1) ? '0 : st_q.ptr + idx_t'(1);

    rb_pick i_pick_load (
        .mask  (mask_in),
        .start ('0),
        .found (load_found),
        .idx   (load_idx)
    );

    rb_pick i_pick_succ (
        .mask  (st_q.mask),
        .start (succ_start),
        .found (succ_found),
        .idx   (succ_idx)
    );

    rb_mux #(.DATA_W(DATA_W), .STATUS_BYTE(STATUS_BYTE)) i_mux (
        .sel   (st_q.ptr),
        .cnt   (byte_cnt),
        .ptr_a (addr_a),
        .ptr_b (addr_b),
        .data  (item_data)
    );

    always_comb begin
        st_d = st_q;
        if (mask_load) begin
            st_d.mask = mask_in;
            st_d.ptr  = load_found ? load_idx : '0;
        end else if (rd_strobe && succ_found) begin
            st_d.ptr  = succ_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mask <= '1;
            st_q.ptr  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = (st_q.mask == '0) ? EMPTY_DATA : item_data;

    // R4 R5: the position always rests on an enabled item
    ptr_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mask != '0) |-> st_q.mask[st_q.ptr]);

    // R4
    ptr_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !mask_load && $countones(st_q.mask) > 1) |=> (st_q.ptr != $past(st_q.ptr)));

    // R5
    single_item_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_load && $countones(st_q.mask) == 1) |=> $stable(st_q.ptr));

    // R7
    empty_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mask == '0 && !mask_load) |=> $stable(st_q.ptr));

    // R7
    empty_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mask == '0) |-> (rd_data == EMPTY_DATA));

    // R2 R9
    load_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_load && mask_in[0]) |=> (st_q.ptr == '0 && st_q.mask == $past(mask_in)));

    // R8
    status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mask != '0 && st_q.ptr == '0) |-> (rd_data == STATUS_BYTE));
endmodule

// File: tb/test_readback_seq.sv
module test_readback_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mask_load = 1'b0;
    logic [6:0]  mask_in = '0;
    logic        rd_strobe = 1'b0;
    logic [15:0] byte_cnt = '0;
    logic [15:0] addr_a = '0;
    logic [15:0] addr_b = '0;
    logic [7:0]  rd_data;

    int checks = 0;
    int fails  = 0;
    logic [6:0] m_mask;
    int         m_ptr;

    readback_seq i_readback_seq (
        .clk, .rst_n, .mask_load, .mask_in, .rd_strobe,
        .byte_cnt, .addr_a, .addr_b, .rd_data
    );

    always #4 clk = ~clk;

    function automatic int lowest(input logic [6:0] m);
        for (int i = 0; i < 7; i++) if (m[i]) return i;
        return 0;
    endfunction

    function automatic int after(input logic [6:0] m, input int p);
        for (int i = 1; i <= 7; i++) if (m[(p + i) % 7]) return (p + i) % 7;
        return p;
    endfunction

    function automatic logic [7:0] expect_data(input logic [6:0] m, input int p);
        if (m == 0) return 8'hFF;
        case (p)
            0: return 8'h5A;
            1: return byte_cnt[7:0];
            2: return byte_cnt[15:8];
            3: return addr_a[7:0];
            4: return addr_a[15:8];
            5: return addr_b[7:0];
            default: return addr_b[15:8];
        endcase
    endfunction

    task automatic check(input string req);
        logic [7:0] exp;
        exp = expect_data(m_mask, m_ptr);
        checks++;
        if (rd_data !== exp) begin
            fails++;
            $display("FAIL %s: rd_data=%h expected=%h (mask=%b pos=%0d)", req, rd_data, exp, m_mask, m_ptr);
        end
    endtask

    task automatic shuffle_live();
        byte_cnt = 16'($urandom);
        addr_a   = 16'($urandom);
        addr_b   = 16'($urandom);
    endtask

    task automatic do_read(input string req);
        @(negedge clk);
        shuffle_live();
        #2 check(req);
        rd_strobe = 1'b1;
        @(posedge clk);
        if (m_mask != 0) m_ptr = after(m_mask, m_ptr);
        #1 rd_strobe = 1'b0;
    endtask

    task automatic do_load(input logic [6:0] m, input logic with_read);
        @(negedge clk);
        mask_in   = m;
        mask_load = 1'b1;
        rd_strobe = with_read;
        @(posedge clk);
        m_mask = m;
        m_ptr  = lowest(m);
        #1 mask_load = 1'b0;
        rd_strobe = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        m_mask = 7'h7F;
        m_ptr  = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 R8: reset state, first read is the status byte
        @(negedge clk); #2 check("R1");
        // R3 R4 R5: all items in order, then wrap
        for (int i = 0; i < 9; i++) do_read("R3");
        // R6: live change without strobe
        @(negedge clk); addr_b = 16'hBEEF; byte_cnt = 16'h1234; addr_a = 16'hC0DE;
        #2 check("R6");
        addr_a = 16'h0F0F; #1 check("R6");
        // R2 R4: skip disabled items
        do_load(7'h41, 1'b0);
        for (int i = 0; i < 4; i++) do_read("R4");
        do_load(7'h28, 1'b0);
        for (int i = 0; i < 4; i++) do_read("R5");
        // R5: single enabled item
        do_load(7'h10, 1'b0);
        for (int i = 0; i < 3; i++) do_read("R5");
        // R7: empty mask reads 0xFF and the position stays
        do_load(7'h00, 1'b0);
        for (int i = 0; i < 3; i++) do_read("R7");
        do_load(7'h7F, 1'b0);
        do_read("R2");
        do_read("R2");
        // R9: load and strobe together
        do_load(7'h0C, 1'b1);
        do_read("R9");
        do_read("R9");
        do_load(7'h7F, 1'b1);
        do_read("R9");

        // random mix
        for (int i = 0; i < 400; i++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 12) do_load(7'($urandom), 1'b0);
            else if (r < 15) do_load((r == 12) ? 7'h00 : 7'(1 << ($urandom % 7)), 1'($urandom));
            else do_read("R4");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule